// File: doc/BRIEF.md
# Untagged Two-Bit Branch History Table

This block predicts, in the fetch stage, whether a conditional branch will be taken. It reads one saturating two-bit counter from a table addressed by the word-index bits of the fetch address, and the counter's upper half gives the prediction in the same cycle. The block treats every lookup as a conditional branch. It does not predict targets and it does not detect whether the fetched instruction is a branch.

The table has no tags and no valid bits. Any two branches whose addresses agree in the index field share one counter, and each sees the other's history. When a branch resolves later in the pipeline, the execution stage presents that branch's address and its real outcome on a separate update port. The addressed counter then moves one step toward the matching end and stays there once it reaches that end.

Top module: `branch_hist_tbl`

## Requirements
- R1: The table index is fetch/update address bits [11:2], giving 1024 counters. Address bits [1:0] and bits above 11 have no effect on which counter is used.
- R2: No tag is stored. Two addresses with equal bits [11:2] read and update the same counter.
- R3: After reset every counter holds the weak not-taken state. It predicts not taken, and a single taken update makes it predict taken.
- R4: Each counter has four states, encoded strong-not-taken=00, weak-not-taken=01, weak-taken=10, strong-taken=11. The prediction is taken exactly in the two taken states (bit 1 set).
- R5: A cycle with upd_valid high moves the counter at upd_pc one step up for upd_taken=1 and one step down for upd_taken=0. No counter changes in a cycle with upd_valid low.
- R6: Counters saturate. A taken update in strong-taken and a not-taken update in strong-not-taken leave the state unchanged.
- R7: pred_taken follows fetch_pc combinationally. An update takes effect on the rising clock edge, so a lookup of the same index in the update cycle returns the state from before the update.
- R8: From weak-taken, the outcome sequence T,T,NT,T,T,NT produces six taken predictions, of which four are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| pred_taken | output | 1 | Prediction for fetch_pc: 1 means taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch: 1 means taken |

## Verification
The bench starts with single steps from reset. A single taken outcome separates a weak reset state from a strong one, and runs of same-direction outcomes expose where the counter saturates at each end. The loop outcome pattern distinguishes a two-bit counter from one that only remembers the last outcome. Address pairs that differ only above bit 11 or only in bits [1:0] show aliasing and the ignored offset bits. A neighbouring index shows that updates stay isolated. A lookup during the update cycle shows the read-before-write order. A pseudo-random stream over a handful of indexes, compared against a model in the bench, covers mixed interleavings.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WNT;

  // One saturating step toward the reported outcome.
  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      case (cur)
        CTR_SNT: nxt = CTR_WNT;
        CTR_WNT: nxt = CTR_WT;
        CTR_WT:  nxt = CTR_ST;
        default: nxt = CTR_ST;
      endcase
    end else begin
      case (cur)
        CTR_ST:  nxt = CTR_WT;
        CTR_WT:  nxt = CTR_WNT;
        CTR_WNT: nxt = CTR_SNT;
        default: nxt = CTR_SNT;
      endcase
    end
    return nxt;
  endfunction

  function automatic logic ctr_leans_taken(ctr_e s);
    return (s == CTR_WT) || (s == CTR_ST);
  endfunction

endpackage

// File: rtl/bht_index_map.sv
module bht_index_map #(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  assign idx = pc[IDX_HI:IDX_LO];

  generate
    if (IDX_LO > 0) begin : g_low_skip
      logic unused_low;
      assign unused_low = ^pc[IDX_LO-1:0];
    end
    if (IDX_HI < PC_W - 1) begin : g_high_skip
      logic unused_high;
      assign unused_high = ^pc[PC_W-1:IDX_HI+1];
    end
  endgenerate
endmodule

// File: rtl/bht_sat_step.sv
module bht_sat_step
  import bht_pkg::*;
(
  input  ctr_e cur,
  input  logic taken,
  output ctr_e nxt
);
  always_comb nxt = ctr_step(cur, taken);
endmodule

// File: rtl/bht_state_array.sv
module bht_state_array
  import bht_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_e             wr_state,
  output ctr_e             wr_old
);
  localparam int ENTRIES = 1 << IDX_W;

  ctr_e cell_w [ENTRIES];

  generate
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cell
      ctr_e cell_q;
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cell_q <= CTR_RESET;
        else if (hit) cell_q <= wr_state;
      end
      assign cell_w[gi] = cell_q;
    end
  endgenerate

  assign rd_state = cell_w[rd_idx];
  assign wr_old   = cell_w[wr_idx];

  // R5: the written value lands in the addressed entry
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cell_w[$past(wr_idx)] == $past(wr_state));

  // R5: with no write, the entry being read keeps its value
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cell_w[$past(rd_idx)] == $past(rd_state));
endmodule

// File: rtl/branch_hist_tbl.sv
module branch_hist_tbl
  import bht_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  logic [IDX_W-1:0] fetch_idx;
  logic [IDX_W-1:0] upd_idx;
  ctr_e             fetch_state;
  ctr_e             upd_old;
  ctr_e             upd_next;
  logic             upd_fire;

  assign upd_fire = upd_valid;

  bht_index_map #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) fetch_map_i (
    .pc(fetch_pc), .idx(fetch_idx));

  bht_index_map #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) upd_map_i (
    .pc(upd_pc), .idx(upd_idx));

  bht_state_array #(.IDX_W(IDX_W)) array_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(fetch_idx), .rd_state(fetch_state),
    .wr_en(upd_fire), .wr_idx(upd_idx), .wr_state(upd_next), .wr_old(upd_old));

  bht_sat_step step_i (.cur(upd_old), .taken(upd_taken), .nxt(upd_next));

  assign pred_taken = ctr_leans_taken(fetch_state);

  // R4: prediction bit agrees with the upper encoding bit of the state read
  p_pred_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken == fetch_state[1]);

  // R5: an update never moves more than one step
  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (upd_next == upd_old) || (upd_next == upd_old + 2'd1) ||
                 (upd_next == upd_old - 2'd1));

  // R5: direction follows the outcome
  p_direction_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (upd_taken ? (upd_next >= upd_old) : (upd_next <= upd_old)));

  // R6: saturation at the taken end
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && upd_taken && upd_old == CTR_ST) |-> upd_next == CTR_ST);

  // R6: saturation at the not-taken end
  p_sat_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !upd_taken && upd_old == CTR_SNT) |-> upd_next == CTR_SNT);

  // R7: the updated entry shows the new state one edge later
  p_next_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && fetch_idx == upd_idx && $stable(fetch_pc)) |=>
      fetch_state == $past(upd_next));
endmodule

// File: tb/branch_hist_tbl_tb_top.sv
module branch_hist_tbl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  int mdl [1024];

  always #5 clk = ~clk;

  branch_hist_tbl dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int slot(logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [31:0] pc);
    fetch_pc = pc;
    #1;
    check_bit(req, pred_taken, mdl[slot(pc)] >= 2);
  endtask

  task automatic push(logic [31:0] pc, logic tk);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    if (tk) mdl[slot(pc)] = (mdl[slot(pc)] == 3) ? 3 : mdl[slot(pc)] + 1;
    else    mdl[slot(pc)] = (mdl[slot(pc)] == 0) ? 0 : mdl[slot(pc)] - 1;
  endtask

  task automatic t_reset;
    look("R3", 32'h0000_0000);
    look("R3", 32'h0000_0ffc);
    check_bit("R3 reset predicts not taken", pred_taken, 1'b0);
    push(32'h0000_0100, 1'b1);
    look("R3", 32'h0000_0100);
    check_bit("R3 one taken step from weak", pred_taken, 1'b1);
  endtask

  task automatic t_loop;
    logic [31:0] pc = 32'h0000_0200;
    logic outs [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    int good = 0;
    push(pc, 1'b1);
    for (int k = 0; k < 6; k++) begin
      look("R8", pc);
      check_bit("R8 loop prediction", pred_taken, 1'b1);
      if (pred_taken == outs[k]) good++;
      push(pc, outs[k]);
    end
    checks++;
    if (good != 4) begin
      errors++;
      $display("FAIL R8 correct count: actual=%0d expected=4", good);
    end
  endtask

  task automatic t_saturate;
    logic [31:0] pc = 32'h0000_0300;
    for (int k = 0; k < 5; k++) push(pc, 1'b1);
    push(pc, 1'b0);
    look("R6", pc);
    check_bit("R6 top saturation", pred_taken, 1'b1);
    push(pc, 1'b0);
    look("R5", pc);
    check_bit("R5 step down", pred_taken, 1'b0);
    for (int k = 0; k < 5; k++) push(pc, 1'b0);
    push(pc, 1'b1);
    look("R6", pc);
    check_bit("R6 bottom saturation", pred_taken, 1'b0);
    push(pc, 1'b1);
    look("R4", pc);
    check_bit("R4 weak taken predicts taken", pred_taken, 1'b1);
  endtask

  task automatic t_alias;
    push(32'h0000_0404, 1'b1);
    look("R2", 32'h0001_0404);
    check_bit("R2 alias shares counter", pred_taken, 1'b1);
    push(32'hfff0_0404, 1'b0);
    look("R2", 32'h0000_0404);
    check_bit("R2 alias update seen", pred_taken, 1'b0);
    push(32'h0000_0503, 1'b1);
    look("R1", 32'h0000_0500);
    check_bit("R1 offset bits ignored", pred_taken, 1'b1);
    look("R1", 32'h0000_0504);
    check_bit("R1 neighbour untouched", pred_taken, 1'b0);
  endtask

  task automatic t_idle;
    logic [31:0] pc = 32'h0000_0600;
    push(pc, 1'b1);
    @(negedge clk);
    upd_pc = pc; upd_taken = 1'b0; upd_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    look("R5", pc);
    check_bit("R5 no update without valid", pred_taken, 1'b1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] pc = 32'h0000_0700;
    @(negedge clk);
    fetch_pc = pc; upd_pc = pc; upd_taken = 1'b1; upd_valid = 1'b1;
    #1;
    check_bit("R7 same cycle old state", pred_taken, 1'b0);
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    mdl[slot(pc)] = 2;
    check_bit("R7 new state after edge", pred_taken, 1'b1);
  endtask

  task automatic t_stream;
    logic [15:0] lfsr = 16'hace1;
    for (int k = 0; k < 200; k++) begin
      logic [31:0] pc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pc = {16'(lfsr), 16'h0800} | {28'd0, lfsr[3:2], 2'b00} | {30'd0, lfsr[5:4]};
      push(pc, lfsr[7]);
      look("R5", {lfsr[15:8], 8'h00, 16'h0800} | {28'd0, lfsr[9:8], 2'b00});
    end
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mdl[k] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_loop();
    t_saturate();
    t_alias();
    t_idle();
    t_same_cycle();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule